// File: doc/BRIEF.md
# DRAM Read-Burst Return Scheduler

This block models the device side of a double-data-rate SDRAM read path in a single clock domain. A command port accepts one command per cycle: an idle slot, a READ that carries a bank, a starting column, an auto-precharge flag and a chop flag, or a mode-load that sets the CAS latency and the additive-latency mode. Each accepted READ is placed in a latency pipeline and comes out read-latency cycles later as a train of data beats. There are two beats per clock, on a rise lane and a fall lane, and they are framed by a strobe preamble and a strobe postamble.

The array itself is not modelled. Each beat carries its own address word `{bank, beat column}`, so the ordering and timing of a burst can be seen directly on the data lanes. READs spaced exactly four cycles apart chain into one continuous stream. A chopped burst followed by a READ four cycles later leaves a gap. A READ that arrives too early is dropped and flagged. A READ with auto precharge asks for its row to be closed once its last beat has left.

Top module: `ddr_rd_return_sched`

## Requirements
- R1: The first data cycle (dq_oe high) of an accepted READ sampled at clock edge k is visible after edge k+RL. RL = CL + AL, where AL is 0 for mode 0, CL-1 for mode 1 and CL-2 for mode 2.
- R2: cmd = 2 loads CL from mode_cl and the AL mode from mode_al. The load is refused, the settings are left unchanged and mode_err pulses for one cycle after the command if CL lies outside 5..11, if the AL mode is 3, or if any READ is still in flight (queued, or with data or the row-close request not yet out).
- R3: Each data cycle carries two beats, the even beat on dq_rise and the odd beat on dq_fall. Each beat is the word `{bank, beat column}`, with the bank in the upper bits.
- R4: A full burst (chop flag 0) lasts four cycles and beat b uses column bits [2:0] = (start + b) mod 8. A chopped burst (chop flag 1) lasts two cycles and beat b uses bits [1:0] = (start + b) mod 4. The upper column bits are kept in both cases.
- R5: For a READ with auto precharge set, close_req pulses with close_bank = the READ's bank in the cycle right after its last data cycle. A READ without auto precharge raises no close_req.
- R6: In the cycle before the first data cycle of a burst that does not directly follow another burst, dqs_oe is high, dqs_hi is low and dq_oe is low (the preamble).
- R7: In every data cycle, dqs_oe and dqs_hi are high, meaning the strobe is high in the first half of the cycle and low in the second half. The second half of the final data cycle is the postamble, and the strobe is released after it unless a preamble follows.
- R8: When no data and no preamble are scheduled, dq_oe, dqs_oe, dqs_hi and both data lanes are 0. This includes the state right after reset.
- R9: A full burst followed by a READ exactly four cycles later produces eight data cycles with no gap and no preamble between them.
- R10: A chopped burst followed by a READ four cycles later leaves two empty cycles. The second of them is the new burst's preamble.
- R11: A READ sampled fewer than 4 cycles after the last accepted READ is dropped and rd_err pulses in the following cycle. A dropped READ does not restart the 4-cycle window.
- R12: After reset, CL is 5 and the AL mode is 0 (RL = 5).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 2 | 0 idle, 1 READ, 2 mode load, 3 treated as idle |
| cmd_bank | input | BANK_W | READ bank |
| cmd_col | input | COL_W | READ start column |
| cmd_ap | input | 1 | Auto precharge on this READ |
| cmd_chop | input | 1 | Chop this READ to four beats |
| mode_cl | input | CLW | CAS latency for a mode load |
| mode_al | input | 2 | Additive-latency mode for a mode load |
| dq_oe | output | 1 | Data lanes driven |
| dq_rise | output | BANK_W+COL_W | Beat in first half of cycle |
| dq_fall | output | BANK_W+COL_W | Beat in second half of cycle |
| dqs_oe | output | 1 | Strobe driven |
| dqs_hi | output | 1 | Strobe high in first half of cycle |
| close_req | output | 1 | Row-close request pulse |
| close_bank | output | BANK_W | Bank to close |
| rd_err | output | 1 | READ spacing violation |
| mode_err | output | 1 | Mode load refused |

## Verification
The hardest case to reach from the ports is the boundary between two bursts. That means a full burst chained into the next one with neither a gap nor a preamble, and a chopped burst followed by a gap whose second cycle is the next preamble. Both have to occur at every latency setting. The bench loads each of the 21 legal CL and AL combinations. For each one it issues a full burst with auto precharge, a chopped burst four cycles later, and another full burst four cycles after that, followed by an early READ and a mode load while busy. A cycle-indexed expectation ring, filled arithmetically at issue time, is then compared against every output in every cycle.

// File: rtl/ddr_rd_pkg.sv
package ddr_rd_pkg;

  typedef enum logic [1:0] {
    CMD_IDLE = 2'd0,
    CMD_READ = 2'd1,
    CMD_MODE = 2'd2,
    CMD_RSVD = 2'd3
  } cmd_e;

  typedef enum logic [1:0] {
    AL_NONE  = 2'd0,
    AL_CLM1  = 2'd1,
    AL_CLM2  = 2'd2,
    AL_ILLEG = 2'd3
  } al_mode_e;

endpackage

// File: rtl/ddr_rd_cmd_ctl.sv
module ddr_rd_cmd_ctl
  import ddr_rd_pkg::*;
#(
  parameter int CL_MIN = 5,
  parameter int CL_MAX = 11,
  parameter int TCCD   = 4,
  parameter int CLW    = 4,
  parameter int RLW    = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [1:0]     cmd,
  input  logic [CLW-1:0] mode_cl,
  input  logic [1:0]     mode_al,
  input  logic           busy,
  output logic           rd_accept,
  output logic [RLW-1:0] rl,
  output logic           rd_err,
  output logic           mode_err
);

  localparam int SW = $clog2(TCCD + 1);

  logic [CLW-1:0] cl_q;
  al_mode_e       al_q;
  logic [SW-1:0]  since_q;
  logic [RLW-1:0] cl_ext;
  logic [RLW-1:0] al_val;
  logic           is_read;
  logic           is_mode;
  logic           mode_ok;

  assign is_read = (cmd == CMD_READ);
  assign is_mode = (cmd == CMD_MODE);
  assign cl_ext  = RLW'(cl_q);

  always_comb begin
    unique case (al_q)
      AL_CLM1: al_val = cl_ext - RLW'(1);
      AL_CLM2: al_val = cl_ext - RLW'(2);
      default: al_val = '0;
    endcase
  end

  assign rl        = cl_ext + al_val;
  assign rd_accept = is_read && (since_q >= SW'(TCCD));
  assign mode_ok   = (mode_cl >= CLW'(CL_MIN)) && (mode_cl <= CLW'(CL_MAX)) &&
                     (mode_al != 2'd3) && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      cl_q     <= CLW'(CL_MIN);
      al_q     <= AL_NONE;
      since_q  <= SW'(TCCD);
      rd_err   <= 1'b0;
      mode_err <= 1'b0;
    end else begin
      rd_err   <= is_read && !rd_accept;
      mode_err <= is_mode && !mode_ok;
      if (is_mode && mode_ok) begin
        cl_q <= mode_cl;
        al_q <= al_mode_e'(mode_al);
      end
      if (rd_accept) begin
        since_q <= SW'(1);
      end else if (since_q < SW'(TCCD)) begin
        since_q <= since_q + SW'(1);
      end
    end
  end

endmodule

// File: rtl/ddr_rd_lat_line.sv
module ddr_rd_lat_line #(
  parameter int DEPTH = 21,
  parameter int ENT_W = 16,
  parameter int RLW   = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [RLW-1:0]   wr_idx,
  input  logic [ENT_W-1:0] wr_data,
  output logic [ENT_W-1:0] head,
  output logic             next_valid,
  output logic             busy
);

  logic [ENT_W-1:0] slot_q [DEPTH];
  logic [ENT_W-1:0] up_w   [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_up
    if (i == DEPTH - 1) begin : g_top
      assign up_w[i] = '0;
    end else begin : g_mid
      assign up_w[i] = slot_q[i+1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (wr_en && (wr_idx == RLW'(i))) slot_q[i] <= wr_data;
        else                              slot_q[i] <= up_w[i];
      end
    end
  end

  always_comb begin
    busy = 1'b0;
    for (int i = 0; i < DEPTH; i++) busy = busy | slot_q[i][ENT_W-1];
  end

  assign head       = slot_q[0];
  assign next_valid = slot_q[1][ENT_W-1];

endmodule

// File: rtl/ddr_rd_burst_gen.sv
module ddr_rd_burst_gen #(
  parameter int BANK_W = 3,
  parameter int COL_W  = 10,
  parameter int ENT_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ENT_W-1:0]        head,
  input  logic                    next_valid,
  output logic                    active,
  output logic                    dq_oe,
  output logic [BANK_W+COL_W-1:0] dq_rise,
  output logic [BANK_W+COL_W-1:0] dq_fall,
  output logic                    dqs_oe,
  output logic                    dqs_hi,
  output logic                    close_req,
  output logic [BANK_W-1:0]       close_bank
);

  localparam int DQ_W = BANK_W + COL_W;

  function automatic logic [COL_W-1:0] beat_col(input logic [COL_W-1:0] c,
                                                input logic chop,
                                                input logic [2:0] b);
    logic [COL_W-1:0] r;
    r = c;
    if (chop) r[1:0] = c[1:0] + b[1:0];
    else      r[2:0] = c[2:0] + b;
    return r;
  endfunction

  logic              h_valid, h_ap, h_chop;
  logic [BANK_W-1:0] h_bank;
  logic [COL_W-1:0]  h_col;

  assign h_valid = head[ENT_W-1];
  assign h_ap    = head[ENT_W-2];
  assign h_chop  = head[ENT_W-3];
  assign h_bank  = head[DQ_W-1:COL_W];
  assign h_col   = head[COL_W-1:0];

  logic              act_q, ap_q, chop_q;
  logic [1:0]        idx_q;
  logic [BANK_W-1:0] bank_q;
  logic [COL_W-1:0]  col_q;

  logic              at_last, adv, data_n;
  logic [1:0]        n_idx;
  logic              n_chop;
  logic [BANK_W-1:0] n_bank;
  logic [COL_W-1:0]  n_col;

  always_comb begin
    at_last = act_q && (idx_q == (chop_q ? 2'd1 : 2'd3));
    adv     = act_q && !at_last;
    data_n  = h_valid || adv;
    n_idx   = h_valid ? 2'd0 : idx_q + 2'd1;
    n_chop  = h_valid ? h_chop : chop_q;
    n_bank  = h_valid ? h_bank : bank_q;
    n_col   = h_valid ? h_col  : col_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q      <= 1'b0;
      ap_q       <= 1'b0;
      chop_q     <= 1'b0;
      idx_q      <= '0;
      bank_q     <= '0;
      col_q      <= '0;
      dq_oe      <= 1'b0;
      dq_rise    <= '0;
      dq_fall    <= '0;
      dqs_oe     <= 1'b0;
      dqs_hi     <= 1'b0;
      close_req  <= 1'b0;
      close_bank <= '0;
    end else begin
      act_q <= data_n;
      idx_q <= data_n ? n_idx : 2'd0;
      if (h_valid) begin
        ap_q   <= h_ap;
        chop_q <= h_chop;
        bank_q <= h_bank;
        col_q  <= h_col;
      end
      dq_oe   <= data_n;
      dq_rise <= data_n ? {n_bank, beat_col(n_col, n_chop, {n_idx, 1'b0})} : '0;
      dq_fall <= data_n ? {n_bank, beat_col(n_col, n_chop, {n_idx, 1'b1})} : '0;
      dqs_oe  <= data_n || next_valid;
      dqs_hi  <= data_n;
      close_req  <= at_last && ap_q;
      close_bank <= (at_last && ap_q) ? bank_q : '0;
    end
  end

  assign active = act_q;

endmodule

// File: rtl/ddr_rd_return_sched.sv
module ddr_rd_return_sched
  import ddr_rd_pkg::*;
#(
  parameter int BANK_W = 3,
  parameter int COL_W  = 10,
  parameter int CL_MIN = 5,
  parameter int CL_MAX = 11,
  parameter int TCCD   = 4,
  parameter int CLW    = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [1:0]              cmd,
  input  logic [BANK_W-1:0]       cmd_bank,
  input  logic [COL_W-1:0]        cmd_col,
  input  logic                    cmd_ap,
  input  logic                    cmd_chop,
  input  logic [CLW-1:0]          mode_cl,
  input  logic [1:0]              mode_al,
  output logic                    dq_oe,
  output logic [BANK_W+COL_W-1:0] dq_rise,
  output logic [BANK_W+COL_W-1:0] dq_fall,
  output logic                    dqs_oe,
  output logic                    dqs_hi,
  output logic                    close_req,
  output logic [BANK_W-1:0]       close_bank,
  output logic                    rd_err,
  output logic                    mode_err
);

  localparam int DEPTH = 2 * CL_MAX - 1;
  localparam int RLW   = $clog2(DEPTH + 1);
  localparam int DQ_W  = BANK_W + COL_W;
  localparam int ENT_W = DQ_W + 3;

  logic             rd_accept;
  logic [RLW-1:0]   rl;
  logic             line_busy;
  logic             eng_active;
  logic [ENT_W-1:0] head;
  logic             next_valid;
  logic [ENT_W-1:0] new_ent;

  assign new_ent = {1'b1, cmd_ap, cmd_chop, cmd_bank, cmd_col};

  ddr_rd_cmd_ctl #(
    .CL_MIN(CL_MIN), .CL_MAX(CL_MAX), .TCCD(TCCD), .CLW(CLW), .RLW(RLW)
  ) u_ctl (
    .clk       (clk),
    .rst       (rst),
    .cmd       (cmd),
    .mode_cl   (mode_cl),
    .mode_al   (mode_al),
    .busy      (line_busy || eng_active),
    .rd_accept (rd_accept),
    .rl        (rl),
    .rd_err    (rd_err),
    .mode_err  (mode_err)
  );

  ddr_rd_lat_line #(
    .DEPTH(DEPTH), .ENT_W(ENT_W), .RLW(RLW)
  ) u_line (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (rd_accept),
    .wr_idx     (rl - RLW'(1)),
    .wr_data    (new_ent),
    .head       (head),
    .next_valid (next_valid),
    .busy       (line_busy)
  );

  ddr_rd_burst_gen #(
    .BANK_W(BANK_W), .COL_W(COL_W), .ENT_W(ENT_W)
  ) u_burst (
    .clk        (clk),
    .rst        (rst),
    .head       (head),
    .next_valid (next_valid),
    .active     (eng_active),
    .dq_oe      (dq_oe),
    .dq_rise    (dq_rise),
    .dq_fall    (dq_fall),
    .dqs_oe     (dqs_oe),
    .dqs_hi     (dqs_hi),
    .close_req  (close_req),
    .close_bank (close_bank)
  );

endmodule

// File: rtl/ddr_rd_return_sched_chk.sv
module ddr_rd_return_sched_chk
  import ddr_rd_pkg::*;
#(
  parameter int BANK_W = 3,
  parameter int COL_W  = 10
) (
  input logic                    clk,
  input logic                    rst,
  input logic [1:0]              cmd,
  input logic                    dq_oe,
  input logic [BANK_W+COL_W-1:0] dq_rise,
  input logic [BANK_W+COL_W-1:0] dq_fall,
  input logic                    dqs_oe,
  input logic                    dqs_hi,
  input logic                    close_req,
  input logic                    rd_err,
  input logic                    mode_err
);

  assert_strobe_in_data_R7: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> (dqs_oe && dqs_hi));

  assert_preamble_low_R6: assert property (@(posedge clk) disable iff (rst)
    (dqs_oe && !dq_oe) |-> !dqs_hi);

  assert_preamble_before_data_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(dq_oe) |-> ($past(dqs_oe) && !$past(dqs_hi)));

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !dqs_oe |-> (!dq_oe && dq_rise == '0 && dq_fall == '0));

  assert_close_after_data_R5: assert property (@(posedge clk) disable iff (rst)
    close_req |-> $past(dq_oe));

  assert_rd_err_cause_R11: assert property (@(posedge clk) disable iff (rst)
    rd_err |-> ($past(cmd) == CMD_READ));

  assert_mode_err_cause_R2: assert property (@(posedge clk) disable iff (rst)
    mode_err |-> ($past(cmd) == CMD_MODE));

endmodule

bind ddr_rd_return_sched ddr_rd_return_sched_chk #(
  .BANK_W(BANK_W), .COL_W(COL_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd       (cmd),
  .dq_oe     (dq_oe),
  .dq_rise   (dq_rise),
  .dq_fall   (dq_fall),
  .dqs_oe    (dqs_oe),
  .dqs_hi    (dqs_hi),
  .close_req (close_req),
  .rd_err    (rd_err),
  .mode_err  (mode_err)
);

// File: tb/ddr_rd_return_sched_bench.sv
module ddr_rd_return_sched_bench;

  localparam int CLK_PERIOD = 10;
  localparam int BANK_W = 3;
  localparam int COL_W  = 10;
  localparam int DQ_W   = BANK_W + COL_W;
  localparam int RING   = 64;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [1:0]        cmd = 2'd0;
  logic [BANK_W-1:0] cmd_bank = '0;
  logic [COL_W-1:0]  cmd_col = '0;
  logic              cmd_ap = 1'b0;
  logic              cmd_chop = 1'b0;
  logic [3:0]        mode_cl = 4'd0;
  logic [1:0]        mode_al = 2'd0;
  logic              dq_oe, dqs_oe, dqs_hi, close_req, rd_err, mode_err;
  logic [DQ_W-1:0]   dq_rise, dq_fall;
  logic [BANK_W-1:0] close_bank;

  ddr_rd_return_sched u_ddr_rd_return_sched (
    .clk(clk), .rst(rst), .cmd(cmd), .cmd_bank(cmd_bank), .cmd_col(cmd_col),
    .cmd_ap(cmd_ap), .cmd_chop(cmd_chop), .mode_cl(mode_cl), .mode_al(mode_al),
    .dq_oe(dq_oe), .dq_rise(dq_rise), .dq_fall(dq_fall), .dqs_oe(dqs_oe),
    .dqs_hi(dqs_hi), .close_req(close_req), .close_bank(close_bank),
    .rd_err(rd_err), .mode_err(mode_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic            e_data  [RING];
  logic            e_pre   [RING];
  logic [DQ_W-1:0] e_rise  [RING];
  logic [DQ_W-1:0] e_fall  [RING];
  logic            e_close [RING];
  logic [BANK_W-1:0] e_cbank [RING];
  logic            e_rderr [RING];
  logic            e_merr  [RING];
  string           e_tag   [RING];

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;
  int m_cl = 5, m_al = 0;
  int last_acc = -100;
  int prev_len = 0;
  int busy_until = -1;

  initial begin
    for (int i = 0; i < RING; i++) begin
      e_data[i] = 0; e_pre[i] = 0; e_rise[i] = '0; e_fall[i] = '0;
      e_close[i] = 0; e_cbank[i] = '0; e_rderr[i] = 0; e_merr[i] = 0; e_tag[i] = "";
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s at cycle %0d: got %0h expected %0h", req, what, cyc, act, exp);
    end
  endtask

  task automatic check_cycle();
    int i;
    logic dqs_exp;
    string t;
    i = cyc % RING;
    dqs_exp = e_data[i] | e_pre[i];
    t = (e_tag[i] != "") ? e_tag[i] : "R1";
    check(dq_oe == e_data[i], t, "dq_oe", 32'(dq_oe), 32'(e_data[i]));
    check(dq_rise == e_rise[i], "R3", "dq_rise", 32'(dq_rise), 32'(e_rise[i]));
    check(dq_fall == e_fall[i], "R4", "dq_fall", 32'(dq_fall), 32'(e_fall[i]));
    check(dqs_oe == dqs_exp, dqs_exp ? "R6" : "R8", "dqs_oe", 32'(dqs_oe), 32'(dqs_exp));
    check(dqs_hi == e_data[i], "R7", "dqs_hi", 32'(dqs_hi), 32'(e_data[i]));
    check(close_req == e_close[i], "R5", "close_req", 32'(close_req), 32'(e_close[i]));
    if (e_close[i])
      check(close_bank == e_cbank[i], "R5", "close_bank", 32'(close_bank), 32'(e_cbank[i]));
    check(rd_err == e_rderr[i], "R11", "rd_err", 32'(rd_err), 32'(e_rderr[i]));
    check(mode_err == e_merr[i], "R2", "mode_err", 32'(mode_err), 32'(e_merr[i]));
    e_data[i] = 0; e_pre[i] = 0; e_rise[i] = '0; e_fall[i] = '0;
    e_close[i] = 0; e_cbank[i] = '0; e_rderr[i] = 0; e_merr[i] = 0; e_tag[i] = "";
  endtask

  always @(negedge clk) if (!rst && !done) check_cycle();

  function automatic logic [DQ_W-1:0] exp_word(input int bank, input int col,
                                               input bit chop, input int beat);
    int c;
    if (chop) c = (col & ~3) | ((col + beat) & 3);
    else      c = (col & ~7) | ((col + beat) & 7);
    return DQ_W'((bank << COL_W) | c);
  endfunction

  task automatic idle(input int n);
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      cmd = 2'd0;
    end
  endtask

  task automatic issue_mode(input int cl, input int al);
    int k;
    @(negedge clk);
    cmd = 2'd2; mode_cl = 4'(cl); mode_al = 2'(al);
    k = cyc + 1;
    if (cl < 5 || cl > 11 || al == 3 || k <= busy_until) begin
      e_merr[k % RING] = 1;   // R2: refused load
    end else begin
      m_cl = cl; m_al = al;
    end
  endtask

  task automatic issue_read(input int bank, input int col, input bit ap,
                            input bit chop, input string first_tag);
    int k, rl, len;
    @(negedge clk);
    cmd = 2'd1; cmd_bank = BANK_W'(bank); cmd_col = COL_W'(col);
    cmd_ap = ap; cmd_chop = chop;
    k = cyc + 1;
    if (k - last_acc < 4) begin
      e_rderr[k % RING] = 1;  // R11: dropped READ
    end else begin
      rl  = m_cl + ((m_al == 0) ? 0 : (m_cl - m_al));
      len = chop ? 2 : 4;
      if (k - last_acc == 4 && prev_len == 4) e_tag[(k + rl) % RING] = "R9";
      if (k - last_acc == 4 && prev_len == 2) e_tag[(k + rl - 2) % RING] = "R10";
      if (first_tag != "") e_tag[(k + rl) % RING] = first_tag;
      e_pre[(k + rl - 1) % RING] = 1;
      for (int c = 0; c < len; c++) begin
        e_data[(k + rl + c) % RING] = 1;
        e_rise[(k + rl + c) % RING] = exp_word(bank, col, chop, 2 * c);
        e_fall[(k + rl + c) % RING] = exp_word(bank, col, chop, 2 * c + 1);
      end
      if (ap) begin
        e_close[(k + rl + len) % RING] = 1;
        e_cbank[(k + rl + len) % RING] = BANK_W'(bank);
      end
      last_acc = k; prev_len = len; busy_until = k + rl + len;
    end
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    idle(3);
    // R12: default latency, first data at RL = 5
    issue_read(5, 10'h3f7, 1'b1, 1'b0, "R12");
    idle(20);
    // Full sweep of legal latency settings (R1, R4, R9, R10, R11, R2)
    for (int cl = 5; cl <= 11; cl++) begin
      for (int al = 0; al <= 2; al++) begin
        issue_mode(cl, al);
        idle(2);
        issue_read(cl % 8, (cl * 73 + al * 5) % 1024, 1'b1, 1'b0, "");
        idle(3);
        issue_read((cl + al) % 8, (cl * 29 + al * 3 + 1) % 1024, 1'b0, 1'b1, "");
        idle(3);
        issue_read((al + 3) % 8, (cl * 11 + al * 7 + 6) % 1024, 1'b1, 1'b0, "");
        idle(1);
        issue_read(1, 5, 1'b1, 1'b0, "");       // too soon: dropped
        issue_mode((cl == 11) ? 5 : cl + 1, 0); // busy: refused
        idle(36);
        issue_mode(4, al);                      // out of range
        issue_mode(cl, 3);                      // illegal AL mode
        idle(2);
      end
    end
    // Chopped read with auto precharge and wrapping start column
    issue_mode(6, 0);
    idle(2);
    issue_read(7, 10'h0ff, 1'b1, 1'b1, "");
    idle(30);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule